// File: doc/BRIEF.md
# Zero-Cross Gated Volume Stage

This block scales a stream of signed PCM samples by a fine gain code in 1 dB steps and a coarse attenuation of 0, 6 or 12 dB, or mutes it. It exists to keep gain changes from clicking. When zero-cross gating is on, a newly written fine code is parked as pending. It moves into use only on a sample where the waveform changes sign or sits exactly at zero. An optional sample-counting timeout forces the pending code in when the signal stays on one side of zero for too long.

Samples enter and leave on valid/ready handshakes. An input sample is taken when `in_valid` and `in_ready` are both high. Its scaled result appears on the output register one cycle later. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` passes straight through to the input. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. Control is written through two plain strobes, one for the fine code and one for the remaining settings. A control write affects samples accepted in later cycles, never the sample accepted in the same cycle.

Top module: `zc_volume_gate`

## Requirements
- R1: After reset the fine code is 0x79 (unity gain), the coarse code is 11 (mute), zero-cross gating and timeout are off, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted sample produces `out_valid`=1 in the next cycle. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data` holds steady.
- R3: With gating off, a fine code written through `vol_we` applies to every sample accepted after the write cycle.
- R4: With gating on, a written fine code stays pending, and samples without a crossing keep the old gain.
- R5: A crossing is an accepted sample whose sign bit (bit DATA_W-1) differs from that of the previous accepted sample, or a sample equal to zero. The crossing sample and all later samples use the pending code.
- R6: With the timeout enabled and no crossing, the pending code applies on the 2^(10+2·rate)-th sample accepted after the last fine-code write.
- R7: A second write while a code is pending replaces it and restarts the timeout count. The earlier pending code is never applied.
- R8: When a fine-code write and a crossing sample fall in the same cycle, that sample uses the previously active gain and the crossing does not apply the new code.
- R9: The fine gain is (code − 0x79) dB. Codes 0x2F and below give a zero output.
- R10: The coarse code selects 00 = 0 dB, 01 = −6 dB (shift right 1), 10 = −12 dB (shift right 2), 11 = zero output. It applies from the next sample on, with or without gating.
- R11: Results beyond the signed DATA_W range saturate to the largest or smallest code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_we | input | 1 | Fine code write strobe |
| vol_code | input | 7 | Fine gain code to write |
| ctl_we | input | 1 | Settings write strobe |
| ctl_attn | input | 2 | Coarse attenuation code |
| ctl_zc_en | input | 1 | Zero-cross gating enable |
| ctl_to_en | input | 1 | Timeout enable |
| ctl_to_rate | input | 2 | Timeout rate select |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 16 | Signed scaled sample |

## Verification
A fine-code write and a zero crossing can land in the same cycle. The write must win: the crossing sample keeps the old gain, and the new code remains pending. The bench provokes this by raising `vol_we` on the same edge as a sample of opposite sign. It then judges the result from the output of that sample, from a following same-sign sample that must still carry the old gain, and from a later crossing that must finally show the new gain. A second overlap, a rewrite arriving partway through the timeout window, is judged by counting accepted samples until the gain changes.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  // Coefficient for a fine code: unity (1 << frac) at the unity code,
  // multiplied by 10^(+-1/20) per step in 16-bit fixed point with rounding.
  function automatic longint gain_coef(input int code, input int unity, input int frac);
    longint c;
    c = longint'(1) << frac;
    if (code >= unity) begin
      for (int i = unity; i < code; i++) c = (c * 73533 + 32768) >>> 16;
    end else begin
      for (int i = code; i < unity; i++) c = (c * 58409 + 32768) >>> 16;
    end
    return c;
  endfunction

  typedef enum logic [1:0] {
    ATT_0DB  = 2'b00,
    ATT_6DB  = 2'b01,
    ATT_12DB = 2'b10,
    ATT_MUTE = 2'b11
  } attn_e;
endpackage

// File: rtl/zcv_gain_rom.sv
module zcv_gain_rom #(
  parameter int VOL_W    = 7,
  parameter int COEF_W   = 16,
  parameter int FRAC     = 14,
  parameter int UNITY    = 121,
  parameter int MUTE_MAX = 47
) (
  input  logic [VOL_W-1:0]  code,
  output logic [COEF_W-1:0] coef
);
  localparam int DEPTH = 1 << VOL_W;

  logic [COEF_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i <= MUTE_MAX) begin : g_mute
      assign rom[i] = '0;
    end else begin : g_gain
      assign rom[i] = COEF_W'(zcv_pkg::gain_coef(i, UNITY, FRAC));
    end
  end

  assign coef = rom[code];
endmodule

// File: rtl/zcv_zc_timer.sv
module zcv_zc_timer #(
  parameter int DATA_W  = 16,
  parameter int VOL_W   = 7,
  parameter int RATE_W  = 2,
  parameter int TO_BASE = 10,
  parameter int UNITY   = 121
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] sample,
  input  logic              vol_we,
  input  logic [VOL_W-1:0]  vol_code,
  input  logic              zc_en,
  input  logic              to_en,
  input  logic [RATE_W-1:0] to_rate,
  output logic [VOL_W-1:0]  eff_code,
  output logic [VOL_W-1:0]  act_code,
  output logic [VOL_W-1:0]  pend_code,
  output logic              pend_q,
  output logic              zc_hit,
  output logic              to_hit
);
  localparam int MAX_RATE = (1 << RATE_W) - 1;
  localparam int CNT_W    = TO_BASE + 2 * MAX_RATE + 1;

  logic              prev_sign;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic              apply;

  assign last   = ({{(CNT_W-1){1'b0}}, 1'b1} << (TO_BASE + 2 * int'(to_rate))) - 1'b1;
  assign zc_hit = (sample[DATA_W-1] != prev_sign) || (sample == '0);
  assign to_hit = to_en && (cnt == last);
  assign apply  = pend_q && accept && !vol_we && (zc_hit || to_hit || !zc_en);

  assign eff_code = apply ? pend_code : act_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_code  <= VOL_W'(UNITY);
      pend_code <= VOL_W'(UNITY);
      pend_q    <= 1'b0;
      prev_sign <= 1'b0;
      cnt       <= '0;
    end else begin
      if (accept) prev_sign <= sample[DATA_W-1];
      if (vol_we) begin
        cnt <= '0;
        if (zc_en) begin
          pend_code <= vol_code;
          pend_q    <= 1'b1;
        end else begin
          act_code <= vol_code;
          pend_q   <= 1'b0;
        end
      end else if (apply) begin
        act_code <= pend_code;
        pend_q   <= 1'b0;
        cnt      <= '0;
      end else if (pend_q && to_en && accept) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zcv_scaler.sv
module zcv_scaler #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0]        coef,
  input  logic [1:0]               attn,
  output logic signed [DATA_W-1:0] result
);
  import zcv_pkg::*;

  localparam int PW = DATA_W + COEF_W + 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'((longint'(1) << (DATA_W-1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = -PW'(longint'(1) << (DATA_W-1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [PW-1:0] shifted;

  assign prod   = PW'(sample) * $signed({1'b0, coef});
  assign scaled = prod >>> FRAC;

  always_comb begin
    result = '0;
    unique case (attn_e'(attn))
      ATT_0DB:  shifted = scaled;
      ATT_6DB:  shifted = scaled >>> 1;
      ATT_12DB: shifted = scaled >>> 2;
      default:  shifted = '0;
    endcase
    if (shifted > SAT_HI)      result = SAT_HI[DATA_W-1:0];
    else if (shifted < SAT_LO) result = SAT_LO[DATA_W-1:0];
    else                       result = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/zc_volume_gate.sv
module zc_volume_gate #(
  parameter int DATA_W   = 16,
  parameter int VOL_W    = 7,
  parameter int COEF_W   = 16,
  parameter int FRAC     = 14,
  parameter int RATE_W   = 2,
  parameter int TO_BASE  = 10,
  parameter int UNITY    = 121,
  parameter int MUTE_MAX = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vol_we,
  input  logic [VOL_W-1:0]  vol_code,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_attn,
  input  logic              ctl_zc_en,
  input  logic              ctl_to_en,
  input  logic [RATE_W-1:0] ctl_to_rate,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [1:0]        attn_q;
  logic              zc_en_q;
  logic              to_en_q;
  logic [RATE_W-1:0] rate_q;
  logic              accept;
  logic [VOL_W-1:0]  eff_code;
  logic [VOL_W-1:0]  act_code;
  logic [VOL_W-1:0]  pend_code;
  logic              pend_q;
  logic              zc_hit;
  logic              to_hit;
  logic [COEF_W-1:0] coef;
  logic [DATA_W-1:0] result;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attn_q  <= 2'b11;
      zc_en_q <= 1'b0;
      to_en_q <= 1'b0;
      rate_q  <= '0;
    end else if (ctl_we) begin
      attn_q  <= ctl_attn;
      zc_en_q <= ctl_zc_en;
      to_en_q <= ctl_to_en;
      rate_q  <= ctl_to_rate;
    end
  end

  zcv_zc_timer #(
    .DATA_W(DATA_W), .VOL_W(VOL_W), .RATE_W(RATE_W),
    .TO_BASE(TO_BASE), .UNITY(UNITY)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(in_data),
    .vol_we(vol_we), .vol_code(vol_code), .zc_en(zc_en_q),
    .to_en(to_en_q), .to_rate(rate_q), .eff_code(eff_code),
    .act_code(act_code), .pend_code(pend_code), .pend_q(pend_q),
    .zc_hit(zc_hit), .to_hit(to_hit)
  );

  zcv_gain_rom #(
    .VOL_W(VOL_W), .COEF_W(COEF_W), .FRAC(FRAC),
    .UNITY(UNITY), .MUTE_MAX(MUTE_MAX)
  ) u_rom (
    .code(eff_code), .coef(coef)
  );

  zcv_scaler #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC)
  ) u_scale (
    .sample(in_data), .coef(coef), .attn(attn_q), .result(result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/zc_volume_gate_chk.sv
module zc_volume_gate_chk #(
  parameter int DATA_W   = 16,
  parameter int VOL_W    = 7,
  parameter int MUTE_MAX = 47
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              accept,
  input logic              vol_we,
  input logic [VOL_W-1:0]  vol_code,
  input logic [1:0]        attn_q,
  input logic              zc_en_q,
  input logic [VOL_W-1:0]  eff_code,
  input logic [VOL_W-1:0]  act_code,
  input logic [VOL_W-1:0]  pend_code,
  input logic              pend_q,
  input logic              zc_hit,
  input logic              to_hit
);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_accept_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we && !zc_en_q |=> act_code == $past(vol_code) && !pend_q);

  assert_pending_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zc_en_q && pend_q && accept && !zc_hit && !to_hit && !vol_we |=> $stable(act_code) && pend_q);

  assert_cross_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && accept && zc_hit && !vol_we |=> !pend_q && act_code == $past(pend_code));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we && zc_en_q |=> pend_q && pend_code == $past(vol_code) && $stable(act_code));

  assert_fine_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (int'(eff_code) <= MUTE_MAX) |=> out_data == '0);

  assert_coarse_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && attn_q == 2'b11 |=> out_data == '0);
endmodule

bind zc_volume_gate zc_volume_gate_chk #(
  .DATA_W(DATA_W), .VOL_W(VOL_W), .MUTE_MAX(MUTE_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .accept(accept), .vol_we(vol_we), .vol_code(vol_code), .attn_q(attn_q),
  .zc_en_q(zc_en_q), .eff_code(eff_code), .act_code(act_code),
  .pend_code(pend_code), .pend_q(pend_q), .zc_hit(zc_hit), .to_hit(to_hit)
);

// File: tb/zc_volume_gate_test.sv
module zc_volume_gate_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vol_we = 1'b0;
  logic [6:0]        vol_code = '0;
  logic              ctl_we = 1'b0;
  logic [1:0]        ctl_attn = '0;
  logic              ctl_zc_en = 1'b0;
  logic              ctl_to_en = 1'b0;
  logic [1:0]        ctl_to_rate = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [15:0]       in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [15:0]       out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  zc_volume_gate uut (
    .clk(clk), .rst_n(rst_n), .vol_we(vol_we), .vol_code(vol_code),
    .ctl_we(ctl_we), .ctl_attn(ctl_attn), .ctl_zc_en(ctl_zc_en),
    .ctl_to_en(ctl_to_en), .ctl_to_rate(ctl_to_rate),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  typedef struct packed {
    logic [6:0]         v;
    logic [1:0]         a;
    logic signed [15:0] s;
    logic signed [15:0] e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{7'h79, 2'b00,  16'sd1000,   16'sd1000},   // R9 unity
    '{7'h79, 2'b01,  16'sd1000,   16'sd500},    // R10 -6 dB
    '{7'h79, 2'b10, -16'sd1000,  -16'sd250},    // R10 -12 dB
    '{7'h79, 2'b11,  16'sd1234,   16'sd0},      // R10 mute
    '{7'h73, 2'b00,  16'sd2000,   16'sd1002},   // R9 -6 dB fine
    '{7'h6D, 2'b00,  16'sd4000,   16'sd1004},   // R9 -12 dB fine
    '{7'h65, 2'b00,  16'sd10000,  16'sd1000},   // R9 -20 dB fine
    '{7'h7F, 2'b00,  16'sd10000,  16'sd19952},  // R9 +6 dB fine
    '{7'h7F, 2'b01,  16'sd10000,  16'sd9976},   // R10 with fine gain
    '{7'h7F, 2'b00,  16'sd30000,  16'sd32767},  // R11 upper clip
    '{7'h7F, 2'b00, -16'sd30000, -16'sd32768},  // R11 lower clip
    '{7'h2F, 2'b00,  16'sd1000,   16'sd0}       // R9 fine mute threshold
  };

  function automatic int model(int v, int a, int s);
    real g;
    int  x;
    if (v <= 47 || a == 3) return 0;
    g = 10.0 ** ((v - 121) / 20.0);
    x = int'($floor(s * g));
    x = x >>> a;
    if (x > 32767) x = 32767;
    if (x < -32768) x = -32768;
    return x;
  endfunction

  task automatic check(string req, int got, int exp, int tol);
    int d;
    checks++;
    d = got - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr_ctl(logic [1:0] a, logic zc, logic to, logic [1:0] r);
    @(negedge clk);
    ctl_we = 1'b1; ctl_attn = a; ctl_zc_en = zc; ctl_to_en = to; ctl_to_rate = r;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_vol(logic [6:0] v);
    @(negedge clk);
    vol_we = 1'b1; vol_code = v;
    @(negedge clk);
    vol_we = 1'b0;
  endtask

  task automatic send(int s, output int got);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(s);
    @(negedge clk);
    in_valid = 1'b0;
    got = int'($signed(out_data));
  endtask

  task automatic send_with_write(int s, logic [6:0] v, output int got);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(s); vol_we = 1'b1; vol_code = v;
    @(negedge clk);
    in_valid = 1'b0; vol_we = 1'b0;
    got = int'($signed(out_data));
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int got;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0, 0);
    check("R1 in_ready", int'(in_ready), 1, 0);
    send(1000, got);
    check("R1 coarse mute at reset", got, 0, 0);
    wr_ctl(2'b00, 1'b0, 1'b0, 2'd0);
    send(1000, got);
    check("R1 unity fine code at reset", got, 1000, 0);

    // table walk, gating off (R3 direct write)
    for (int i = 0; i < NV; i++) begin
      wr_ctl(VECS[i].a, 1'b0, 1'b0, 2'd0);
      wr_vol(VECS[i].v);
      send(int'(VECS[i].s), got);
      check("R3/R9/R10/R11 vector", got, int'(VECS[i].e), 3);
    end

    // R4 / R5 gating
    wr_ctl(2'b00, 1'b1, 1'b0, 2'd0);
    wr_vol(7'h79);
    send(-1000, got);
    send(1000, got);
    check("R5 crossing apply unity", got, 1000, 0);
    wr_vol(7'h73);
    send(1000, got);
    check("R4 pending not applied", got, 1000, 0);
    send(1200, got);
    check("R4 pending still held", got, 1200, 0);
    send(-1000, got);
    check("R5 sign change applies", got, model(7'h73, 0, -1000), 3);
    send(-1000, got);
    check("R5 stays applied", got, model(7'h73, 0, -1000), 3);
    // R5 zero sample from the negative side: apply at zero, then check
    wr_vol(7'h79);
    send(0, got);
    send(-800, got);
    check("R5 zero sample applies", got, -800, 0);
    // R5 zero sample with positive history
    send(800, got);
    wr_vol(7'h73);
    send(0, got);
    send(800, got);
    check("R5 zero sample only trigger", got, model(7'h73, 0, 800), 3);

    // R7 replace pending
    wr_vol(7'h6D);
    send(1000, got);
    check("R7 old gain kept", got, model(7'h73, 0, 1000), 3);
    wr_vol(7'h7F);
    send(-1000, got);
    check("R7 latest pending applied", got, model(7'h7F, 0, -1000), 3);

    // R8 write and crossing in one cycle
    send_with_write(1000, 7'h79, got);
    check("R8 crossing sample keeps old", got, model(7'h7F, 0, 1000), 3);
    send(1000, got);
    check("R8 new code still pending", got, model(7'h7F, 0, 1000), 3);
    send(-1000, got);
    check("R8 later crossing applies", got, -1000, 0);

    // R6 timeout, R7 restart
    wr_ctl(2'b00, 1'b1, 1'b1, 2'd0);
    wr_vol(7'h73);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      send(-1000, got);
      if (got != -1000) bad++;
    end
    check("R6 no early apply", bad, 0, 0);
    wr_vol(7'h6D);
    bad = 0;
    for (int i = 0; i < 1023; i++) begin
      send(-1000, got);
      if (got != -1000) bad++;
    end
    check("R7 timeout restarted by rewrite", bad, 0, 0);
    send(-1000, got);
    check("R6 timeout applies on 1024th", got, model(7'h6D, 0, -1000), 3);

    // R10 coarse change immediate under gating
    wr_vol(7'h79);
    wr_ctl(2'b01, 1'b1, 1'b0, 2'd0);
    send(-2000, got);
    check("R10 coarse immediate with pending", got, model(7'h6D, 1, -2000), 3);
    wr_ctl(2'b11, 1'b1, 1'b0, 2'd0);
    send(-2000, got);
    check("R10 coarse mute immediate", got, 0, 0);

    // R2 back-pressure
    wr_ctl(2'b00, 1'b0, 1'b0, 2'd0);
    wr_vol(7'h79);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 16'sd700;
    @(negedge clk);
    in_data = 16'sd900;
    check("R2 out_valid after accept", int'(out_valid), 1, 0);
    check("R2 in_ready low in stall", int'(in_ready), 0, 0);
    @(negedge clk);
    @(negedge clk);
    check("R2 data held in stall", int'($signed(out_data)), 700, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next sample after release", int'($signed(out_data)), 900, 0);
    @(negedge clk);
    check("R2 out_valid drops when drained", int'(out_valid), 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule